// File: doc/BRIEF.md
# Dual Reference Selection Supervisor

This block is the digital supervisor of a clock synchronizer with two reference inputs. It watches two reference inputs, each nominally 8 kHz, and reports which one the downstream phase loop should follow. It also decides when the loop must fall back to free running. It does not switch between references on its own. The select pin always decides which input is used. When the selected input fails, the block raises a combined alarm so that a higher layer can rearrange the references. Free run is entered automatically only when both inputs are silent, or on demand through a force pin.

Each reference passes through a synchronizer and a rising-edge detector into an activity monitor. The monitor declares the reference lost after a programmable number of system-clock cycles with no edge. It declares the reference present again after a programmable run of edges that each arrive in time. After a switch of the select pin, or when the selected reference comes back, a qualification timer runs. While it runs, the lock-loss term of the alarm is masked. When the block is in automatic free run, it returns to tracking only after the selected reference has stayed present for the whole qualification window.

Top module: `refsel_supervisor`

## Requirements
- R1: `use_b` shows the sampled select pin: 0 selects reference A and 1 selects reference B. It never changes because of reference activity.
- R2: If the selected reference shows no rising edge for more than `LOS_TIMEOUT` cycles, the alarm goes high. A shorter gap leaves the alarm low.
- R3: A reference pulse as short as 12.5 ns is seen as activity, provided the system clock period is shorter than that pulse.
- R4: A lost reference is declared present again only after `RESTORE_EDGES` rising edges, each arriving within `LOS_TIMEOUT` cycles of the previous one. Fewer edges keep the alarm high.
- R5: When the selected reference is present, lock is reported (`lock_ok` = 1) and no free run is active, the alarm is low. The alarm stays low even if the unselected reference is lost.
- R6: When both references are lost, `free_run` goes high and the alarm goes high.
- R7: A high on `force_free` drives `free_run` high whatever the references do. Releasing the pin returns `free_run` to low when the references are good.
- R8: After a change of the select pin, or when the selected reference is declared present again, the lock-loss term of the alarm is masked for `QUAL_CYCLES` cycles. After that, a low `lock_ok` raises the alarm.
- R9: Automatic free run ends only after the selected reference has been present for `QUAL_CYCLES` cycles. Until then, `free_run` and the alarm both stay high.
- R10: A high on `rst`, sampled on the clock, puts the block into automatic free run with the alarm high and both references treated as lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_a | input | 1 | Reference input A |
| ref_b | input | 1 | Reference input B |
| sel_b | input | 1 | Reference select: 0 = A, 1 = B |
| force_free | input | 1 | Force free run, active high |
| lock_ok | input | 1 | Lock status from the phase loop, 1 = locked |
| use_b | output | 1 | Chosen reference: 0 = A, 1 = B |
| free_run | output | 1 | Free-run status, active high |
| alarm | output | 1 | Combined loss-of-reference / loss-of-lock alarm |

## Verification
A table walks the block through a set of combinations:
- both references present under each select value;
- only the unselected reference lost;
- only the selected reference lost;
- lock loss on a good reference;
- both references lost;
- forced free run.

Together these separate a missing selected reference from a missing unselected one, and loss of lock from loss of reference. Directed sequences then cover several timing cases. A reference is stopped and checked before and after the timeout. Narrow pulses are fed one at a time, to show that one pulse short of the restore count keeps the alarm high. The select pin is switched together with a loss of lock, to place the end of the mask window. One reference returns from automatic free run, to show that free run lasts through the qualification window.

// File: rtl/refsel_pkg.sv
`timescale 1ns/1ps
package refsel_pkg;
   localparam int NUM_REFS = 2;

   typedef enum logic {
      REF_A = 1'b0,
      REF_B = 1'b1
   } ref_id_e;

   function automatic int cnt_w(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction
endpackage

// File: rtl/refsel_sync.sv
`timescale 1ns/1ps
module refsel_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("refsel_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("refsel_sync: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      end else begin
         stg[0] <= d;
         for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/refsel_act_mon.sv
`timescale 1ns/1ps
module refsel_act_mon #(
   parameter int unsigned TIMEOUT = 31250,
   parameter int unsigned RESTORE = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_s,
   output logic active,
   output logic edge_o
);
   localparam int GW = refsel_pkg::cnt_w(TIMEOUT);
   localparam int EW = refsel_pkg::cnt_w(RESTORE);
   localparam logic [GW-1:0] GAP_MAX  = GW'(TIMEOUT);
   localparam logic [EW-1:0] GOOD_MAX = EW'(RESTORE);

   logic          prev;
   logic [GW-1:0] gap;
   logic [EW-1:0] good;
   logic [EW-1:0] good_nxt;

   assign edge_o   = ref_s & ~prev;
   assign good_nxt = (gap == GAP_MAX) ? EW'(1) : good + EW'(1);

   always_ff @(posedge clk) begin
      if (rst) begin
         prev   <= 1'b0;
         gap    <= GAP_MAX;
         good   <= '0;
         active <= 1'b0;
      end else begin
         prev <= ref_s;
         if (edge_o) begin
            gap <= '0;
            if (!active) begin
               if (good_nxt == GOOD_MAX) begin
                  active <= 1'b1;
                  good   <= '0;
               end else begin
                  good <= good_nxt;
               end
            end
         end else if (gap != GAP_MAX) begin
            gap <= gap + GW'(1);
         end else begin
            active <= 1'b0;
            good   <= '0;
         end
      end
   end
endmodule

// File: rtl/refsel_qual_timer.sv
`timescale 1ns/1ps
module refsel_qual_timer #(
   parameter int unsigned QUAL = 62_500_000
) (
   input  logic clk,
   input  logic rst,
   input  logic start,
   input  logic sel_act,
   output logic busy,
   output logic done
);
   localparam int QW = refsel_pkg::cnt_w(QUAL);
   localparam logic [QW-1:0] QLOAD = QW'(QUAL);

   logic [QW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst)               cnt <= '0;
      else if (start)        cnt <= QLOAD;
      else if (!sel_act)     cnt <= '0;
      else if (cnt != '0)    cnt <= cnt - QW'(1);
   end

   assign busy = (cnt != '0);
   assign done = (cnt == QW'(1)) && sel_act && !start;
endmodule

// File: rtl/refsel_supervisor.sv
`timescale 1ns/1ps
module refsel_supervisor #(
   parameter int unsigned LOS_TIMEOUT   = 31250,
   parameter int unsigned RESTORE_EDGES = 2,
   parameter int unsigned QUAL_CYCLES   = 62_500_000,
   parameter int          SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic ref_a,
   input  logic ref_b,
   input  logic sel_b,
   input  logic force_free,
   input  logic lock_ok,
   output logic use_b,
   output logic free_run,
   output logic alarm
);
   import refsel_pkg::*;

   generate
      if (LOS_TIMEOUT < 2) begin : g_bad_timeout
         $error("refsel_supervisor: LOS_TIMEOUT must be at least 2");
      end
      if (RESTORE_EDGES < 1) begin : g_bad_restore
         $error("refsel_supervisor: RESTORE_EDGES must be at least 1");
      end
      if (QUAL_CYCLES < 2) begin : g_bad_qual
         $error("refsel_supervisor: QUAL_CYCLES must be at least 2");
      end
   endgenerate

   logic [NUM_REFS-1:0] ref_raw, ref_s, act, ref_edge;
   logic [1:0]          ctrl_s;
   logic                force_s;
   ref_id_e             sel_id;
   logic                sel_q, sel_act, sel_act_q;
   logic                qual_start, qual_busy, qual_done;
   logic                auto_free, alarm_q;

   assign ref_raw = {ref_b, ref_a};

   refsel_sync #(.WIDTH(NUM_REFS), .STAGES(SYNC_STAGES)) u_ref_sync (
      .clk (clk), .rst (rst), .d (ref_raw), .q (ref_s)
   );

   refsel_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_ctrl_sync (
      .clk (clk), .rst (rst), .d ({force_free, sel_b}), .q (ctrl_s)
   );

   assign sel_id  = ref_id_e'(ctrl_s[0]);
   assign force_s = ctrl_s[1];

   for (genvar g = 0; g < NUM_REFS; g++) begin : g_mon
      refsel_act_mon #(.TIMEOUT(LOS_TIMEOUT), .RESTORE(RESTORE_EDGES)) u_mon (
         .clk    (clk),
         .rst    (rst),
         .ref_s  (ref_s[g]),
         .active (act[g]),
         .edge_o (ref_edge[g])
      );
   end

   assign sel_act    = (sel_id == REF_B) ? act[REF_B] : act[REF_A];
   assign qual_start = (ctrl_s[0] != sel_q) || (sel_act && !sel_act_q);

   refsel_qual_timer #(.QUAL(QUAL_CYCLES)) u_qual (
      .clk     (clk),
      .rst     (rst),
      .start   (qual_start),
      .sel_act (sel_act),
      .busy    (qual_busy),
      .done    (qual_done)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_q     <= 1'b0;
         sel_act_q <= 1'b0;
         auto_free <= 1'b1;
         alarm_q   <= 1'b1;
      end else begin
         sel_q     <= ctrl_s[0];
         sel_act_q <= sel_act;
         if (act == '0)      auto_free <= 1'b1;
         else if (qual_done) auto_free <= 1'b0;
         alarm_q <= !sel_act || (!lock_ok && !qual_busy) || auto_free;
      end
   end

   assign use_b    = ctrl_s[0];
   assign free_run = force_s || auto_free;
   assign alarm    = alarm_q;
endmodule

// File: rtl/refsel_supervisor_chk.sv
`timescale 1ns/1ps
module refsel_supervisor_chk (
   input logic       clk,
   input logic       rst,
   input logic       sel_b,
   input logic       force_free,
   input logic       lock_ok,
   input logic       use_b,
   input logic       free_run,
   input logic       alarm,
   input logic [1:0] act,
   input logic [1:0] edg,
   input logic       sel_act,
   input logic       qual,
   input logic       auto_free
);
   // R1: select output follows the pin after the two synchronizer stages
   a_r1_use_tracks_select: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2)) |-> (use_b == $past(sel_b, 2)));

   // R2: a lost selected reference raises the alarm
   a_r2_lost_selected_alarms: assert property (@(posedge clk) disable iff (rst)
      !sel_act |=> alarm);

   // R4: a monitor returns to active only on a detected edge
   a_r4_restore_a_on_edge: assert property (@(posedge clk) disable iff (rst)
      $rose(act[0]) |-> $past(edg[0]));
   a_r4_restore_b_on_edge: assert property (@(posedge clk) disable iff (rst)
      $rose(act[1]) |-> $past(edg[1]));

   // R5: good selected reference with lock gives a quiet alarm
   a_r5_quiet_when_good: assert property (@(posedge clk) disable iff (rst)
      (sel_act && lock_ok && !auto_free) |=> !alarm);

   // R6: both references gone leads to free run with alarm
   a_r6_both_gone_free: assert property (@(posedge clk) disable iff (rst)
      (act == 2'b00) |=> (free_run && alarm));

   // R7: the force pin reaches the free-run status
   a_r7_force_free: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(rst, 2) && $past(force_free, 2)) |-> free_run);

   // R8: lock loss is masked while qualifying
   a_r8_blank_lol: assert property (@(posedge clk) disable iff (rst)
      (sel_act && qual && !auto_free) |=> !alarm);

   // R9: automatic free run ends only with the selected reference present
   a_r9_exit_needs_ref: assert property (@(posedge clk) disable iff (rst)
      $fell(auto_free) |-> $past(sel_act));
endmodule

bind refsel_supervisor refsel_supervisor_chk u_chk (
   .clk        (clk),
   .rst        (rst),
   .sel_b      (sel_b),
   .force_free (force_free),
   .lock_ok    (lock_ok),
   .use_b      (use_b),
   .free_run   (free_run),
   .alarm      (alarm),
   .act        (act),
   .edg        (ref_edge),
   .sel_act    (sel_act),
   .qual       (qual_busy),
   .auto_free  (auto_free)
);

// File: tb/tb_refsel_supervisor.sv
`timescale 1ns/1ps
module tb_refsel_supervisor;
   localparam int TO   = 40;
   localparam int RE   = 3;
   localparam int QU   = 300;
   localparam int REFP = 16;     // reference period in clock cycles
   localparam int SETTLE = 700;

   // {en_a, en_b, sel, force, lock, exp_use_b, exp_free, exp_alarm}
   localparam logic [7:0] VEC [0:7] = '{
      8'b11001_000,
      8'b11101_100,
      8'b01101_100,
      8'b01001_001,
      8'b10000_001,
      8'b00001_011,
      8'b11011_010,
      8'b11001_000
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ref_a = 1'b0, ref_b = 1'b0;
   logic sel_b = 1'b0, force_free = 1'b0, lock_ok = 1'b1;
   logic en_a = 1'b0, en_b = 1'b0;
   logic use_b, free_run, alarm;
   int   n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   refsel_supervisor #(
      .LOS_TIMEOUT(TO), .RESTORE_EDGES(RE), .QUAL_CYCLES(QU), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst(rst), .ref_a(ref_a), .ref_b(ref_b), .sel_b(sel_b),
      .force_free(force_free), .lock_ok(lock_ok),
      .use_b(use_b), .free_run(free_run), .alarm(alarm)
   );

   // 12.5 ns wide pulses, one per REFP cycles
   always begin
      if (en_a) begin ref_a = 1'b1; #12.5; ref_a = 1'b0; #(REFP*8 - 12.5); end
      else #8;
   end
   always begin
      if (en_b) begin ref_b = 1'b1; #12.5; ref_b = 1'b0; #(REFP*8 - 12.5); end
      else #8;
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act_v, input logic exp_v, input string what);
      n_chk++;
      if (act_v !== exp_v) begin
         n_bad++;
         $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act_v, exp_v, $time);
      end
   endtask

   task automatic pulse_a();
      ref_a = 1'b1; #12.5; ref_a = 1'b0;
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      summary();
      $finish;
   end

   initial begin
      // R10: state during and just after reset
      wait_cyc(4);
      chk("R10", free_run, 1'b1, "free_run in reset");
      chk("R10", alarm, 1'b1, "alarm in reset");
      rst = 1'b0;
      wait_cyc(3);
      chk("R10", free_run, 1'b1, "free_run after reset");
      chk("R10", alarm, 1'b1, "alarm after reset");
      chk("R1", use_b, 1'b0, "use_b after reset");

      // table walk
      for (int i = 0; i < 8; i++) begin
         {en_a, en_b, sel_b, force_free, lock_ok} = VEC[i][7:3];
         wait_cyc(SETTLE);
         chk("R1", use_b, VEC[i][2], $sformatf("vector %0d use_b", i));
         chk("R6 R7", free_run, VEC[i][1], $sformatf("vector %0d free_run", i));
         chk("R2 R5", alarm, VEC[i][0], $sformatf("vector %0d alarm", i));
      end

      // R2: stop the selected reference, check before and after the timeout
      en_a = 1'b0;
      wait_cyc(10);
      chk("R2", alarm, 1'b0, "alarm before timeout");
      wait_cyc(70);
      chk("R2", alarm, 1'b1, "alarm after timeout");
      chk("R1", use_b, 1'b0, "no automatic switch to B");

      // R3 R4: narrow pulses, one short of the restore count, then the last one
      pulse_a(); wait_cyc(REFP);
      pulse_a(); wait_cyc(10);
      chk("R4", alarm, 1'b1, "alarm with RE-1 edges");
      wait_cyc(REFP - 10);
      pulse_a(); wait_cyc(10);
      chk("R3,R4", alarm, 1'b0, "alarm after RE narrow edges");
      en_a = 1'b1;
      wait_cyc(400);

      // R8: switch select, then drop lock inside the window
      sel_b = 1'b1;
      wait_cyc(5);
      lock_ok = 1'b0;
      wait_cyc(40);
      chk("R1", use_b, 1'b1, "use_b after switch");
      chk("R8", alarm, 1'b0, "lock loss masked in window");
      wait_cyc(300);
      chk("R8", alarm, 1'b1, "lock loss shown after window");
      lock_ok = 1'b1;
      wait_cyc(5);

      // R9: both lost, then B returns
      en_a = 1'b0; en_b = 1'b0;
      wait_cyc(100);
      chk("R6", free_run, 1'b1, "free_run with both lost");
      en_b = 1'b1;
      wait_cyc(150);
      chk("R9", free_run, 1'b1, "free_run held while qualifying");
      chk("R9", alarm, 1'b1, "alarm held while qualifying");
      wait_cyc(350);
      chk("R9", free_run, 1'b0, "free_run cleared after qualification");
      chk("R9", alarm, 1'b0, "alarm cleared after qualification");

      // R7: force and release with good references
      en_a = 1'b1;
      wait_cyc(100);
      force_free = 1'b1;
      wait_cyc(10);
      chk("R7", free_run, 1'b1, "forced free run");
      force_free = 1'b0;
      wait_cyc(10);
      chk("R7", free_run, 1'b0, "force released");

      // R10: reset in the middle of operation
      rst = 1'b1;
      wait_cyc(3);
      chk("R10", free_run, 1'b1, "free_run on mid-run reset");
      chk("R10", alarm, 1'b1, "alarm on mid-run reset");
      rst = 1'b0;
      wait_cyc(SETTLE);
      chk("R9", free_run, 1'b0, "recovered after reset");

      summary();
      $finish;
   end
endmodule